// File: doc/BRIEF.md
# Secure/Privilege Register Access Filter

This block fronts a small bank of 32-bit configuration registers and judges every bus access against two attributes carried with it: whether it is secure and whether it is privileged. A strap input turns the security model on or off for the whole chip. A secure-configuration register inside the bank holds per-group bits that make further registers secure-only. One register takes its per-bit security from an input vector that comes from peripheral firewall logic outside the block.

An access that is refused returns zero on a read and leaves the register unchanged on a write. When a refusal is caused by the security rules and the access was nonsecure, the block raises a one-cycle illegal-access event together with the response. A refusal caused only by privilege is silent. Responses are registered: a request presented in one cycle is answered in the next cycle, with read data and event aligned.

Register layout (byte offsets, word aligned): 0x00 secure configuration (bit 0 guards 0x1C and 0x24, bit 1 guards 0x14, bit 3 guards 0x08), 0x04 per-bit guarded configuration (bits 19:16 and 9:8), 0x08 interrupt mask (bits 5:0), 0x0C nonsecure lock (bits 1:0), 0x10 secure lock (bits 2:0), 0x14 break-link lock (bits 3:0), 0x1C compensation control (bits 3:0), 0x24 compensation code (bits 15:0).

Top module: `regacc_guard`

## Requirements
- R1: After reset the mask register reads 0x0000001F, the compensation code register reads 0x00007878, every other register reads 0, and rsp_valid_o and illegal_evt_o are 0.
- R2: A request accepted in cycle n is answered in cycle n+1 with rsp_valid_o high; a write answers with rsp_rdata_o equal to 0; illegal_evt_o is high only in a response cycle and only for one cycle per offending request.
- R3: With sec_en_i low, offset 0x00 reads zero, ignores writes and never raises the event.
- R4: With sec_en_i high, offset 0x00 is readable by any access; a nonsecure write is dropped and raises the event; a secure write updates bits 0 and 1, and bit 3 only when the write is also privileged.
- R5: With sec_en_i high and a group bit set, every register in that group refuses nonsecure reads and writes and raises the event; with the group bit clear, nonsecure access works normally.
- R6: Offset 0x10 is read-as-zero and write-ignored with no event while sec_en_i is low; while sec_en_i is high a nonsecure access to it is refused with the event.
- R7: Offsets 0x08, 0x0C and 0x10 refuse unprivileged reads and writes without raising the event.
- R8: An access refused both for privilege and for security returns zero and raises the event exactly once.
- R9: At offset 0x04, while sec_en_i is high, a nonsecure access reads zero in each bit whose cfg1_sec_i bit is set and cannot change such a bit, with no event; other bits behave normally.
- R10: Offsets 0x0C, 0x10 and 0x14 are write-one-to-set: writing 0 never clears a bit, only reset clears them.
- R11: Unmapped or misaligned addresses and reserved bits read zero, writes to them have no effect, and no event is raised.
- R12: The event is never raised for a secure access nor while sec_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en_i | input | 1 | Global security-enable strap |
| cfg1_sec_i | input | 32 | Per-bit security flags for offset 0x04 |
| req_valid_i | input | 1 | Access request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_secure_i | input | 1 | Access is secure |
| req_priv_i | input | 1 | Access is privileged |
| rsp_valid_o | output | 1 | Response cycle |
| rsp_rdata_o | output | 32 | Read data, zero when refused or on writes |
| illegal_evt_o | output | 1 | One-cycle illegal-access event |

## Verification
A corrupted group bit or lock bit shows at the ports on the very next access to the guarded register: read data appears where zero was due, or an event appears or goes missing in that response cycle. A bad write mask shows one access later, when a read returns a value the reference model did not let change. The bench compares response valid, data and event against a behavioural model on every clock, so any divergence is caught in the cycle it first reaches the outputs.

// File: rtl/regacc_guard_pkg.sv
package regacc_guard_pkg;

    localparam int DW   = 32;
    localparam int NREG = 8;
    localparam int ID_W = 4;

    // Group-bit positions inside the secure-configuration register
    localparam int GRP_STAT_BIT = 0;
    localparam int GRP_CFG2_BIT = 1;
    localparam int GRP_MASK_BIT = 3;

    typedef enum logic [ID_W-1:0] {
        RG_SCR   = 4'd0,
        RG_CFG1  = 4'd1,
        RG_MASK  = 4'd2,
        RG_NSLK  = 4'd3,
        RG_SLK   = 4'd4,
        RG_CFG2  = 4'd5,
        RG_CCTL  = 4'd6,
        RG_CCODE = 4'd7,
        RG_NONE  = 4'd8
    } reg_id_e;

    typedef struct packed {
        logic [DW-1:0] rd_mask;
        logic [DW-1:0] wr_mask;
        logic          evt;
    } verdict_t;

    function automatic int reg_word(input int i);
        case (i)
            0: return 0;  1: return 1;  2: return 2;  3: return 3;
            4: return 4;  5: return 5;  6: return 7;  default: return 9;
        endcase
    endfunction

    function automatic logic [DW-1:0] impl_mask(input int i);
        case (i)
            0: return 32'h0000_000B;
            1: return 32'h000F_0300;
            2: return 32'h0000_003F;
            3: return 32'h0000_0003;
            4: return 32'h0000_0007;
            5: return 32'h0000_000F;
            6: return 32'h0000_000F;
            default: return 32'h0000_FFFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] rst_val(input int i);
        case (i)
            2: return 32'h0000_001F;
            7: return 32'h0000_7878;
            default: return '0;
        endcase
    endfunction

    function automatic bit set_only(input int i);
        return (i == 3) || (i == 4) || (i == 5);
    endfunction

endpackage

// File: rtl/regacc_guard_dec.sv
module regacc_guard_dec
    import regacc_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_id_e           id_o
);
    localparam int WA_W = ADDR_W - 2;

    always_comb begin
        id_o = RG_NONE;
        if (addr_i[1:0] == 2'b00) begin
            for (int i = 0; i < NREG; i++) begin
                if (addr_i[ADDR_W-1:2] == WA_W'(reg_word(i)))
                    id_o = reg_id_e'(ID_W'(i));
            end
        end
    end
endmodule

// File: rtl/regacc_guard_policy.sv
module regacc_guard_policy
    import regacc_guard_pkg::*;
(
    input  reg_id_e       id_i,
    input  logic          is_write_i,
    input  logic          secure_i,
    input  logic          priv_i,
    input  logic          sec_en_i,
    input  logic          grp_stat_i,
    input  logic          grp_cfg2_i,
    input  logic          grp_mask_i,
    input  logic [DW-1:0] cfg1_sec_i,
    output verdict_t      verdict_o
);
    logic          rd_ok, wr_ok, viol, need_priv;
    logic [DW-1:0] bit_rd, bit_wr;
    logic          ns_guarded;

    assign ns_guarded = sec_en_i && !secure_i;

    always_comb begin
        rd_ok     = 1'b1;
        wr_ok     = 1'b1;
        viol      = 1'b0;
        need_priv = 1'b0;
        bit_rd    = '1;
        bit_wr    = '1;
        unique case (id_i)
            RG_SCR: begin
                if (!sec_en_i) begin
                    rd_ok = 1'b0;
                    wr_ok = 1'b0;
                end else begin
                    if (!secure_i) begin
                        wr_ok = 1'b0;
                        viol  = is_write_i;
                    end
                    if (!priv_i) bit_wr[GRP_MASK_BIT] = 1'b0;
                end
            end
            RG_CFG1: begin
                if (ns_guarded) begin
                    bit_rd = ~cfg1_sec_i;
                    bit_wr = ~cfg1_sec_i;
                end
            end
            RG_MASK: begin
                need_priv = 1'b1;
                viol      = ns_guarded && grp_mask_i;
            end
            RG_NSLK: need_priv = 1'b1;
            RG_SLK: begin
                need_priv = 1'b1;
                if (!sec_en_i) begin
                    rd_ok = 1'b0;
                    wr_ok = 1'b0;
                end else begin
                    viol = !secure_i;
                end
            end
            RG_CFG2:          viol = ns_guarded && grp_cfg2_i;
            RG_CCTL, RG_CCODE: viol = ns_guarded && grp_stat_i;
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
        if (viol || (need_priv && !priv_i)) begin
            rd_ok = 1'b0;
            wr_ok = 1'b0;
        end
        verdict_o.rd_mask = rd_ok ? bit_rd : '0;
        verdict_o.wr_mask = wr_ok ? bit_wr : '0;
        verdict_o.evt     = viol;
    end
endmodule

// File: rtl/regacc_guard_bank.sv
module regacc_guard_bank
    import regacc_guard_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  reg_id_e                  id_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic [DW-1:0]            wmask_i,
    output logic [NREG-1:0][DW-1:0]  regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] IMPL = impl_mask(g);
        localparam logic [DW-1:0] RSTV = rst_val(g);
        logic [DW-1:0] q, nxt, m;

        assign m = wmask_i & IMPL;

        if (set_only(g)) begin : g_w1s
            assign nxt = q | (wdata_i & m);
        end else begin : g_rw
            assign nxt = (q & ~m) | (wdata_i & m);
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= RSTV;
            else if (we_i && (id_i == reg_id_e'(ID_W'(g))))
                q <= nxt;
        end

        assign regs_o[g] = q;
    end
endmodule

// File: rtl/regacc_guard.sv
module regacc_guard
    import regacc_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_en_i,
    input  logic [31:0]       cfg1_sec_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    input  logic              req_secure_i,
    input  logic              req_priv_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              illegal_evt_o
);
    reg_id_e                 id;
    verdict_t                vd;
    logic [NREG-1:0][DW-1:0] regs;
    logic [DW-1:0]           scr;
    logic [DW-1:0]           rd_val;

    assign scr = regs[RG_SCR];

    regacc_guard_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (req_addr_i),
        .id_o   (id)
    );

    regacc_guard_policy pol_i (
        .id_i       (id),
        .is_write_i (req_write_i),
        .secure_i   (req_secure_i),
        .priv_i     (req_priv_i),
        .sec_en_i   (sec_en_i),
        .grp_stat_i (scr[GRP_STAT_BIT]),
        .grp_cfg2_i (scr[GRP_CFG2_BIT]),
        .grp_mask_i (scr[GRP_MASK_BIT]),
        .cfg1_sec_i (cfg1_sec_i),
        .verdict_o  (vd)
    );

    regacc_guard_bank bank_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (req_valid_i && req_write_i),
        .id_i    (id),
        .wdata_i (req_wdata_i),
        .wmask_i (vd.wr_mask),
        .regs_o  (regs)
    );

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (id == reg_id_e'(ID_W'(i))) rd_val = regs[i] & vd.rd_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o   <= 1'b0;
            rsp_rdata_o   <= '0;
            illegal_evt_o <= 1'b0;
        end else begin
            rsp_valid_o   <= req_valid_i;
            rsp_rdata_o   <= (req_valid_i && !req_write_i) ? rd_val : '0;
            illegal_evt_o <= req_valid_i && vd.evt;
        end
    end
endmodule

// File: rtl/regacc_guard_chk.sv
module regacc_guard_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_en_i,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              req_secure_i,
    input logic              req_priv_i,
    input logic              rsp_valid_o,
    input logic [31:0]       rsp_rdata_o,
    input logic              illegal_evt_o
);
    logic mapped, priv_only;

    assign mapped = (req_addr_i == ADDR_W'(8'h00)) || (req_addr_i == ADDR_W'(8'h04)) ||
                    (req_addr_i == ADDR_W'(8'h08)) || (req_addr_i == ADDR_W'(8'h0C)) ||
                    (req_addr_i == ADDR_W'(8'h10)) || (req_addr_i == ADDR_W'(8'h14)) ||
                    (req_addr_i == ADDR_W'(8'h1C)) || (req_addr_i == ADDR_W'(8'h24));
    assign priv_only = (req_addr_i == ADDR_W'(8'h08)) || (req_addr_i == ADDR_W'(8'h0C)) ||
                       (req_addr_i == ADDR_W'(8'h10));

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_valid_o && !illegal_evt_o));

    p_write_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i) |=> (rsp_rdata_o == 32'd0));

    p_scr_off_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !sec_en_i && req_addr_i == ADDR_W'(8'h00)) |=>
            (rsp_rdata_o == 32'd0 && !illegal_evt_o));

    p_unpriv_hidden_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i && !req_priv_i && priv_only) |=> (rsp_rdata_o == 32'd0));

    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !mapped) |=> (rsp_rdata_o == 32'd0 && !illegal_evt_o));

    p_evt_source_r12: assert property (@(posedge clk) disable iff (rst)
        illegal_evt_o |-> $past(req_valid_i && !req_secure_i && sec_en_i));
endmodule

bind regacc_guard regacc_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sec_en_i      (sec_en_i),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_secure_i  (req_secure_i),
    .req_priv_i    (req_priv_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .illegal_evt_o (illegal_evt_o)
);

// File: tb/regacc_guard_tb_top.sv
`timescale 1ns/1ps
module regacc_guard_tb_top;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          sec_en = 1'b0;
    logic [31:0]   c1sec = '0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, evt;
    logic [31:0]   rsp_rdata;

    regacc_guard #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .sec_en_i(sec_en), .cfg1_sec_i(c1sec),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_secure_i(req_secure), .req_priv_i(req_priv),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .illegal_evt_o(evt)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_scr, m_cfg1, m_mask, m_nslk, m_slk, m_cfg2, m_cctl, m_ccode;
    bit          exp_v, exp_e;
    logic [31:0] exp_d;
    string       exp_tag;

    task automatic mreset();
        m_scr = 0; m_cfg1 = 0; m_mask = 32'h1F; m_nslk = 0;
        m_slk = 0; m_cfg2 = 0; m_cctl = 0; m_ccode = 32'h7878;
        exp_v = 0; exp_e = 0; exp_d = 0;
    endtask

    task automatic mdl(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit s, input bit p, output logic [31:0] rd, output bit ev);
        bit nsb;
        logic [31:0] vis;
        rd = '0; ev = 0;
        nsb = sec_en && !s;
        case (a)
            8'h00: if (sec_en) begin
                if (!w) rd = m_scr;
                else if (!s) ev = 1;
                else m_scr = {28'd0, (p ? d[3] : m_scr[3]), 1'b0, d[1:0]};
            end
            8'h04: begin
                vis = (nsb ? ~c1sec : 32'hFFFF_FFFF) & 32'h000F_0300;
                if (w) m_cfg1 = (m_cfg1 & ~vis) | (d & vis);
                else rd = m_cfg1 & vis;
            end
            8'h08: begin
                ev = nsb && m_scr[3];
                if (!ev && p) begin
                    if (w) m_mask = d & 32'h3F; else rd = m_mask;
                end
            end
            8'h0C: if (p) begin
                if (w) m_nslk = m_nslk | (d & 32'h3); else rd = m_nslk;
            end
            8'h10: if (sec_en) begin
                ev = !s;
                if (!ev && p) begin
                    if (w) m_slk = m_slk | (d & 32'h7); else rd = m_slk;
                end
            end
            8'h14: begin
                ev = nsb && m_scr[1];
                if (!ev) begin
                    if (w) m_cfg2 = m_cfg2 | (d & 32'hF); else rd = m_cfg2;
                end
            end
            8'h1C: begin
                ev = nsb && m_scr[0];
                if (!ev) begin
                    if (w) m_cctl = d & 32'hF; else rd = m_cctl;
                end
            end
            8'h24: begin
                ev = nsb && m_scr[0];
                if (!ev) begin
                    if (w) m_ccode = d & 32'hFFFF; else rd = m_ccode;
                end
            end
            default: ;
        endcase
    endtask

    task automatic cmp();
        n_run++;
        if (rsp_valid !== exp_v || rsp_rdata !== exp_d || evt !== exp_e) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b d=%h e=%0b expected v=%0b d=%h e=%0b",
                     exp_tag, rsp_valid, rsp_rdata, evt, exp_v, exp_d, exp_e);
        end
    endtask

    task automatic step(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d,
                        input bit s, input bit p, input string tag);
        logic [31:0] rd;
        bit ev;
        @(negedge clk);
        cmp();
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        req_secure = s; req_priv = p;
        if (v) begin
            mdl(w, a, d, s, p, rd, ev);
            exp_v = 1; exp_d = w ? 32'd0 : rd; exp_e = ev;
        end else begin
            exp_v = 0; exp_d = 0; exp_e = 0;
        end
        exp_tag = tag;
    endtask

    task automatic rd_(input logic [7:0] a, input bit s, input bit p, input string tag);
        step(1, 0, a, 32'd0, s, p, tag);
    endtask
    task automatic wr_(input logic [7:0] a, input logic [31:0] d, input bit s, input bit p,
                       input string tag);
        step(1, 1, a, d, s, p, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, 8'h00, 32'd0, 0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmp();
        rst = 1; req_valid = 0;
        repeat (2) @(negedge clk);
        mreset();
        exp_tag = "R1 reset outputs";
        rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        mreset();
        exp_tag = "R1 reset outputs";
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        rd_(8'h08, 1, 1, "R1 mask reset");
        rd_(8'h24, 1, 1, "R1 code reset");
        rd_(8'h1C, 1, 1, "R1 ctl reset");
        rd_(8'h14, 1, 1, "R1 cfg2 reset");
        rd_(8'h0C, 1, 1, "R1 nslock reset");
        // Security disabled
        wr_(8'h00, 32'hF, 1, 1, "R3 scr write off");
        rd_(8'h00, 1, 1, "R3 scr read off");
        wr_(8'h10, 32'h7, 1, 1, "R6 slock write off");
        rd_(8'h10, 1, 1, "R6 slock read off");
        wr_(8'h1C, 32'hF, 0, 0, "R5 ctl open");
        rd_(8'h1C, 0, 0, "R5 ctl open read");
        wr_(8'h14, 32'h1, 0, 0, "R10 cfg2 set a");
        wr_(8'h14, 32'h2, 0, 0, "R10 cfg2 set b");
        wr_(8'h14, 32'h0, 0, 0, "R10 cfg2 zero write");
        rd_(8'h14, 0, 0, "R10 cfg2 sticky");
        wr_(8'h0C, 32'h3, 1, 0, "R7 nslock unpriv write");
        rd_(8'h0C, 1, 1, "R7 nslock unchanged");
        wr_(8'h0C, 32'h1, 1, 1, "R10 nslock set a");
        wr_(8'h0C, 32'h2, 1, 1, "R10 nslock set b");
        wr_(8'h0C, 32'h0, 1, 1, "R10 nslock zero");
        rd_(8'h0C, 1, 1, "R10 nslock sticky");
        rd_(8'h08, 1, 0, "R7 mask unpriv read");
        wr_(8'h08, 32'h0, 1, 0, "R7 mask unpriv write");
        rd_(8'h08, 1, 1, "R7 mask unchanged");
        wr_(8'h18, 32'hFFFF_FFFF, 1, 1, "R11 unmapped write");
        rd_(8'h18, 1, 1, "R11 unmapped read");
        rd_(8'h3C, 0, 0, "R11 unmapped read hi");
        rd_(8'h26, 1, 1, "R11 misaligned read");
        wr_(8'h24, 32'hFFFF_FFFF, 1, 1, "R11 reserved bits");
        rd_(8'h24, 1, 1, "R11 reserved readback");
        wr_(8'h24, 32'h1234, 0, 0, "R5 code write");
        c1sec = 32'hFFFF_FFFF;
        wr_(8'h04, 32'hFFFF_FFFF, 0, 0, "R9 cfg1 off write");
        rd_(8'h04, 0, 0, "R9 cfg1 off read");
        idle("R2 idle");
        // Security enabled
        sec_en = 1;
        rd_(8'h00, 0, 0, "R4 scr ns read");
        wr_(8'h00, 32'hF, 1, 0, "R4 scr sec unpriv write");
        rd_(8'h00, 0, 1, "R4 scr bit3 kept");
        wr_(8'h00, 32'h0, 0, 1, "R4 scr ns write event");
        idle("R2 event one cycle");
        rd_(8'h00, 1, 1, "R4 scr unchanged");
        wr_(8'h00, 32'hB, 1, 1, "R4 scr sec priv write");
        rd_(8'h00, 1, 0, "R4 scr readback");
        rd_(8'h1C, 0, 1, "R5 ctl ns read guarded");
        rd_(8'h1C, 1, 0, "R5 ctl sec read");
        wr_(8'h24, 32'h5555, 0, 1, "R5 code ns write guarded");
        rd_(8'h24, 1, 1, "R5 code unchanged");
        wr_(8'h14, 32'h8, 0, 1, "R5 cfg2 ns write guarded");
        rd_(8'h14, 1, 1, "R5 cfg2 unchanged");
        rd_(8'h08, 0, 1, "R5 mask ns guarded");
        rd_(8'h08, 0, 0, "R8 mask double block");
        rd_(8'h08, 1, 0, "R7 mask sec unpriv");
        wr_(8'h08, 32'h2A, 1, 1, "R5 mask sec write");
        rd_(8'h08, 1, 1, "R5 mask readback");
        wr_(8'h10, 32'h7, 0, 1, "R6 slock ns write");
        wr_(8'h10, 32'h5, 1, 1, "R6 slock sec write");
        rd_(8'h10, 1, 1, "R6 slock readback");
        rd_(8'h10, 0, 0, "R8 slock double block");
        wr_(8'h10, 32'h2, 1, 0, "R7 slock unpriv write");
        rd_(8'h10, 1, 1, "R10 slock sticky");
        idle("R2 idle");
        c1sec = 32'h0005_0100;
        rd_(8'h04, 0, 0, "R9 cfg1 ns masked read");
        wr_(8'h04, 32'h0, 0, 0, "R9 cfg1 ns write");
        rd_(8'h04, 1, 0, "R9 cfg1 secured bits kept");
        wr_(8'h04, 32'h0, 1, 0, "R9 cfg1 sec write");
        rd_(8'h04, 0, 0, "R9 cfg1 cleared");
        wr_(8'h00, 32'hA, 1, 1, "R5 clear group0");
        rd_(8'h1C, 0, 0, "R5 ctl ns open again");
        rd_(8'h00, 0, 0, "R12 scr ns read no event");
        rd_(8'h14, 1, 0, "R12 secure no event");
        idle("R2 idle");
        // Reset clears set-only locks
        do_reset();
        rd_(8'h0C, 1, 1, "R10 nslock cleared by reset");
        rd_(8'h14, 1, 1, "R10 cfg2 cleared by reset");
        rd_(8'h10, 1, 1, "R10 slock cleared by reset");
        rd_(8'h00, 1, 1, "R1 scr after reset");
        idle("R2 idle");
        idle("R2 idle");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule